// File: doc/BRIEF.md
# Receive Descriptor List Walker

This block is the descriptor engine of a receive DMA path. Software builds a list of 16-byte descriptors in memory, points the list base input at the first one, and pulses the enable-set input. The engine then reads each descriptor over a one-word request/acknowledge memory port. When the descriptor's ownership flag shows that it belongs to the engine, the engine gives the buffer address and size to an external data mover. It waits until the mover reports that a frame has completed, then writes the outcome back into the descriptor and moves on to the next one.

Each descriptor holds three words. Word 0 at offset 0 carries the flags. Word 1 at offset 4 holds the buffer size in bits [31:16] and the received length in bits [15:0]. Word 2 at offset 8 holds the buffer address. A descriptor may be flagged as the end of the list. After such a descriptor the walk returns to the list base address; otherwise it continues at the next 16-byte slot. If the engine reads a descriptor it does not own, it drops the enable bit and stops.

Top module: `rxdw_top`

## Requirements
- R1: After reset, en_o is 0, idle_o is 1, mem_req is 0 and buf_valid is 0.
- R2: A pulse on en_set while idle sets en_o and makes the first memory access a read of word 0 at the current base_addr.
- R3: When word 0 bit 31 (owned flag) is 1, the engine reads offset 4 and then offset 8. It then holds buf_valid high with buf_addr equal to word 2 and buf_size equal to word 1 bits [31:16] until xfer_done.
- R4: When a fetched word 0 has bit 31 equal to 0, en_o falls and idle_o rises. The engine issues no further memory access and never raises buf_valid for that descriptor.
- R5: After xfer_done, the engine writes word 1 at offset 4 as {buf_size, stored length}. It then writes word 0 at offset 0 with bit 31 = 0, bit 30 unchanged, bit 29 = xfer_err, bit 28 = xfer_last, bit 27 = overflow and all other bits 0.
- R6: If xfer_len exceeds buf_size, the stored length equals buf_size and the overflow bit (word 0 bit 27) is 1. Otherwise the stored length equals xfer_len and the overflow bit is 0. A length equal to the size does not count as overflow.
- R7: When word 0 bit 30 (list-end flag) is 0, the next fetch reads the descriptor pointer plus 16.
- R8: When word 0 bit 30 is 1, the next fetch reads base_addr.
- R9: Owned descriptors are processed back to back with no further software action.
- R10: A pulse on en_clr clears en_o. The descriptor in progress still completes its write-back, after which the engine goes idle without fetching again.
- R11: Once mem_req is raised, it stays high until mem_ack, with mem_addr, mem_we and mem_wdata held unchanged.
- R12: idle_o is 1 only while the engine is stopped. While idle it makes no memory request and shows no buffer to the mover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | AW | List base address register value |
| en_set | input | 1 | Software write of 1 to the receive enable |
| en_clr | input | 1 | Software write of 0 to the receive enable |
| en_o | output | 1 | Receive enable bit state |
| idle_o | output | 1 | Engine stopped between lists |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| buf_valid | output | 1 | Buffer offered to the data mover |
| buf_addr | output | AW | Buffer start address |
| buf_size | output | 16 | Buffer size in bytes |
| xfer_done | input | 1 | Frame finished (single-cycle pulse) |
| xfer_len | input | 16 | Received frame length in bytes |
| xfer_err | input | 1 | Frame had an error |
| xfer_last | input | 1 | Frame ended in this buffer |

## Verification
The assertions assume that mem_ack rises only while mem_req is high, lasts one cycle, and comes with valid read data. They also assume that xfer_done arrives only while buf_valid is high. The bench memory model acknowledges an access one cycle after it sees the request and drops the acknowledge in the next cycle. The mover model pulses completion a fixed number of cycles after a buffer is offered. Every list the bench builds ends in a descriptor the engine does not own, so each scenario stops by itself.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 16;
  localparam int STRIDE  = 16;
  localparam int OFS_W1  = 4;
  localparam int OFS_W2  = 8;
  localparam int B_OWN   = 31;
  localparam int B_END   = 30;
  localparam int B_ERR   = 29;
  localparam int B_LAST  = 28;
  localparam int B_OVF   = 27;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_RD2,
    ST_XFER,
    ST_WB1,
    ST_WB0
  } walk_st_t;
endpackage

// File: rtl/rxdw_next_ptr.sv
module rxdw_next_ptr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_ptr,
  input  logic [AW-1:0] base_addr,
  input  logic          list_end,
  output logic [AW-1:0] next_ptr
);
  localparam logic [AW-1:0] STEP = AW'(rxdw_pkg::STRIDE);

  always_comb begin
    if (list_end) next_ptr = base_addr;
    else          next_ptr = cur_ptr + STEP;
  end
endmodule

// File: rtl/rxdw_len_clip.sv
module rxdw_len_clip #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] frame_len,
  input  logic [LW-1:0] buf_size,
  output logic [LW-1:0] kept_len,
  output logic          overflow
);
  always_comb begin
    overflow = (frame_len > buf_size);
    kept_len = overflow ? buf_size : frame_len;
  end
endmodule

// File: rtl/rxdw_wb_pack.sv
module rxdw_wb_pack
  import rxdw_pkg::*;
(
  input  logic             list_end,
  input  logic             frm_err,
  input  logic             frm_last,
  input  logic             overflow,
  input  logic [LEN_W-1:0] size,
  input  logic [LEN_W-1:0] kept_len,
  output logic [WORD_W-1:0] word0,
  output logic [WORD_W-1:0] word1
);
  always_comb begin
    word0         = '0;
    word0[B_OWN]  = 1'b0;
    word0[B_END]  = list_end;
    word0[B_ERR]  = frm_err;
    word0[B_LAST] = frm_last;
    word0[B_OVF]  = overflow;
    word1         = {size, kept_len};
  end
endmodule

// File: rtl/rxdw_top.sv
module rxdw_top
  import rxdw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     base_addr,
  input  logic              en_set,
  input  logic              en_clr,
  output logic              en_o,
  output logic              idle_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              buf_valid,
  output logic [AW-1:0]     buf_addr,
  output logic [LEN_W-1:0]  buf_size,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_err,
  input  logic              xfer_last
);
  walk_st_t          st_q, st_d;
  logic              en_q, en_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              end_q, end_d;
  logic [LEN_W-1:0]  size_q, size_d;
  logic [AW-1:0]     baddr_q, baddr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              ovf_q, ovf_d;
  logic              err_q, err_d;
  logic              last_q, last_d;

  logic [AW-1:0]     nxt_ptr;
  logic [LEN_W-1:0]  clip_len;
  logic              clip_ovf;
  logic [WORD_W-1:0] wb_w0, wb_w1;

  rxdw_next_ptr #(.AW(AW)) u_next (
    .cur_ptr   (ptr_q),
    .base_addr (base_addr),
    .list_end  (end_q),
    .next_ptr  (nxt_ptr)
  );

  rxdw_len_clip #(.LW(LEN_W)) u_clip (
    .frame_len (xfer_len),
    .buf_size  (size_q),
    .kept_len  (clip_len),
    .overflow  (clip_ovf)
  );

  rxdw_wb_pack u_pack (
    .list_end (end_q),
    .frm_err  (err_q),
    .frm_last (last_q),
    .overflow (ovf_q),
    .size     (size_q),
    .kept_len (len_q),
    .word0    (wb_w0),
    .word1    (wb_w1)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    en_d    = en_q;
    ptr_d   = ptr_q;
    end_d   = end_q;
    size_d  = size_q;
    baddr_d = baddr_q;
    len_d   = len_q;
    ovf_d   = ovf_q;
    err_d   = err_q;
    last_d  = last_q;

    if (en_clr)      en_d = 1'b0;
    else if (en_set) en_d = 1'b1;

    unique case (st_q)
      ST_IDLE: begin
        if (en_set && !en_clr) begin
          ptr_d = base_addr;
          st_d  = ST_RD0;
        end
      end
      ST_RD0: begin
        if (mem_ack) begin
          if (!mem_rdata[B_OWN]) begin
            en_d = 1'b0;
            st_d = ST_IDLE;
          end else begin
            end_d = mem_rdata[B_END];
            st_d  = ST_RD1;
          end
        end
      end
      ST_RD1: begin
        if (mem_ack) begin
          size_d = mem_rdata[WORD_W-1 -: LEN_W];
          st_d   = ST_RD2;
        end
      end
      ST_RD2: begin
        if (mem_ack) begin
          baddr_d = mem_rdata[AW-1:0];
          st_d    = ST_XFER;
        end
      end
      ST_XFER: begin
        if (xfer_done) begin
          len_d  = clip_len;
          ovf_d  = clip_ovf;
          err_d  = xfer_err;
          last_d = xfer_last;
          st_d   = ST_WB1;
        end
      end
      ST_WB1: begin
        if (mem_ack) st_d = ST_WB0;
      end
      ST_WB0: begin
        if (mem_ack) begin
          ptr_d = nxt_ptr;
          st_d  = en_d ? ST_RD0 : ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      en_q <= 1'b0;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  // datapath registers, no reset needed
  always_ff @(posedge clk) begin
    ptr_q   <= ptr_d;
    end_q   <= end_d;
    size_q  <= size_d;
    baddr_q <= baddr_d;
    len_q   <= len_d;
    ovf_q   <= ovf_d;
    err_q   <= err_d;
    last_q  <= last_d;
  end

  // memory port decode
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = '0;
    unique case (st_q)
      ST_RD0: mem_req = 1'b1;
      ST_RD1: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + AW'(OFS_W1);
      end
      ST_RD2: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + AW'(OFS_W2);
      end
      ST_WB1: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q + AW'(OFS_W1);
        mem_wdata = wb_w1;
      end
      ST_WB0: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = wb_w0;
      end
      default: ;
    endcase
  end

  assign en_o      = en_q;
  assign idle_o    = (st_q == ST_IDLE);
  assign buf_valid = (st_q == ST_XFER);
  assign buf_addr  = baddr_q;
  assign buf_size  = size_q;
endmodule

// File: rtl/rxdw_chk.sv
module rxdw_chk
  import rxdw_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input walk_st_t          st,
  input logic              en_o,
  input logic              idle_o,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [AW-1:0]     mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [WORD_W-1:0] mem_rdata,
  input logic              buf_valid
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_halt_unowned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD0 && mem_ack && !mem_rdata[B_OWN]) |=> (!en_o && idle_o && !mem_req));

  p_release_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB0 && mem_req) |-> (mem_we && !mem_wdata[B_OWN]));

  p_len_clip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB1 && mem_req) |-> (mem_wdata[LEN_W-1:0] <= mem_wdata[WORD_W-1 -: LEN_W]));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (!mem_req && !buf_valid));

  p_wb1_before_wb0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB1 && mem_ack) |=> (st == ST_WB0));
endmodule

bind rxdw_top rxdw_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st        (st_q),
  .en_o      (en_o),
  .idle_o    (idle_o),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .buf_valid (buf_valid)
);

// File: tb/tb_rxdw_top.sv
module tb_rxdw_top;
  localparam int AW = 32;

  logic              clk, rst_n;
  logic [AW-1:0]     base_addr;
  logic              en_set, en_clr, en_o, idle_o;
  logic              mem_req, mem_we, mem_ack;
  logic [AW-1:0]     mem_addr;
  logic [31:0]       mem_wdata, mem_rdata;
  logic              buf_valid;
  logic [AW-1:0]     buf_addr;
  logic [15:0]       buf_size;
  logic              xfer_done;
  logic [15:0]       xfer_len;
  logic              xfer_err, xfer_last;

  rxdw_top #(.AW(AW)) dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [256];
  logic [31:0] log_addr [64];
  logic        log_we   [64];
  logic [31:0] log_data [64];
  int          nlog;
  logic [15:0] fr_len  [8];
  logic        fr_err  [8];
  logic        fr_last [8];
  logic [31:0] seen_addr [8];
  logic [15:0] seen_size [8];
  int          nfr;
  int          mv_cnt;
  int          hold_viol;
  logic        prev_wait;
  logic [31:0] prev_addr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: ack one cycle after request, one cycle long
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      if (nlog < 64) begin
        log_addr[nlog] <= mem_addr;
        log_we[nlog]   <= mem_we;
        log_data[nlog] <= mem_wdata;
      end
      nlog <= nlog + 1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // request hold monitor for R11
  always @(posedge clk) begin
    if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_viol <= hold_viol + 1;
    prev_wait <= mem_req && !mem_ack;
    prev_addr <= mem_addr;
  end

  // data mover model
  always @(posedge clk) begin
    if (buf_valid && !xfer_done) begin
      if (mv_cnt == 3) begin
        xfer_done <= 1'b1;
        xfer_len  <= fr_len[nfr];
        xfer_err  <= fr_err[nfr];
        xfer_last <= fr_last[nfr];
        seen_addr[nfr] <= buf_addr;
        seen_size[nfr] <= buf_size;
        nfr    <= nfr + 1;
        mv_cnt <= 0;
      end else begin
        mv_cnt <= mv_cnt + 1;
      end
    end else begin
      xfer_done <= 1'b0;
    end
  end

  task automatic clear_env();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) begin
      fr_len[i] = '0; fr_err[i] = 1'b0; fr_last[i] = 1'b0;
    end
    nlog = 0; nfr = 0; mv_cnt = 0; hold_viol = 0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
    mem[(a >> 2)]     = w0;
    mem[(a >> 2) + 1] = w1;
    mem[(a >> 2) + 2] = w2;
  endtask

  task automatic start();
    @(negedge clk); en_set = 1'b1;
    @(negedge clk); en_set = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while (!idle_o && t < 2000) begin
      @(negedge clk); t++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 en_o", {31'd0, en_o}, 32'd0);
    chk("R1 idle_o", {31'd0, idle_o}, 32'd1);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 buf_valid", {31'd0, buf_valid}, 32'd0);
  endtask

  task automatic t_single();
    bit busy_seen = 0;
    clear_env();
    base_addr = 32'h100;
    put_desc(32'h100, 32'h8000_0000, 32'h0040_0000, 32'h2000_0000);
    fr_len[0] = 16'd40; fr_err[0] = 1'b1; fr_last[0] = 1'b1;
    @(negedge clk); en_set = 1'b1;
    @(negedge clk); en_set = 1'b0;
    chk("R2 en_o set", {31'd0, en_o}, 32'd1);
    chk("R12 busy not idle", {31'd0, idle_o}, 32'd0);
    wait_idle();
    chk("R2 first read addr", log_addr[0], 32'h100);
    chk("R2 first is read", {31'd0, log_we[0]}, 32'd0);
    chk("R3 word1 addr", log_addr[1], 32'h104);
    chk("R3 word2 addr", log_addr[2], 32'h108);
    chk("R3 buf_addr", seen_addr[0], 32'h2000_0000);
    chk("R3 buf_size", {16'd0, seen_size[0]}, 32'd64);
    chk("R5 wb1 addr", log_addr[3], 32'h104);
    chk("R5 wb1 data", log_data[3], 32'h0040_0028);
    chk("R5 wb0 addr", log_addr[4], 32'h100);
    chk("R5 wb0 data", log_data[4], 32'h3000_0000);
    chk("R7 next fetch", log_addr[5], 32'h110);
    chk("R4 no access after unowned", nlog, 6);
    chk("R4 en_o cleared", {31'd0, en_o}, 32'd0);
    chk("R4 no buffer offered", nfr, 1);
    chk("R11 request hold", hold_viol, 0);
    if (busy_seen) ;
  endtask

  task automatic t_overflow();
    clear_env();
    base_addr = 32'h100;
    put_desc(32'h100, 32'h8000_0000, 32'h0020_0000, 32'h3000_0000);
    put_desc(32'h110, 32'h8000_0000, 32'h0020_0000, 32'h3100_0000);
    fr_len[0] = 16'd50;
    fr_len[1] = 16'd32;
    start();
    wait_idle();
    chk("R6 clipped len", mem[32'h104 >> 2], 32'h0020_0020);
    chk("R6 ovf flag", mem[32'h100 >> 2], 32'h0800_0000);
    chk("R6 equal len kept", mem[32'h114 >> 2], 32'h0020_0020);
    chk("R6 equal no ovf", mem[32'h110 >> 2], 32'h0000_0000);
    chk("R9 two frames", nfr, 2);
  endtask

  task automatic t_wrap();
    clear_env();
    base_addr = 32'h100;
    put_desc(32'h100, 32'h8000_0000, 32'h0040_0000, 32'h4000_0000);
    put_desc(32'h110, 32'h8000_0000, 32'h0040_0000, 32'h4100_0000);
    put_desc(32'h120, 32'hC000_0000, 32'h0040_0000, 32'h4200_0000);
    fr_len[0] = 16'd10; fr_len[1] = 16'd20; fr_len[2] = 16'd30;
    start();
    wait_idle();
    chk("R9 three frames", nfr, 3);
    chk("R9 third buffer", seen_addr[2], 32'h4200_0000);
    chk("R8 fetch after end at base", log_addr[nlog-1], 32'h100);
    chk("R5 end flag kept", mem[32'h120 >> 2], 32'h4000_0000);
    chk("R8 halted en_o", {31'd0, en_o}, 32'd0);
  endtask

  task automatic t_stop();
    int t = 0;
    clear_env();
    base_addr = 32'h100;
    put_desc(32'h100, 32'h8000_0000, 32'h0040_0000, 32'h5000_0000);
    put_desc(32'h110, 32'h8000_0000, 32'h0040_0000, 32'h5100_0000);
    fr_len[0] = 16'd8; fr_len[1] = 16'd8;
    start();
    while (!buf_valid && t < 200) begin
      @(negedge clk); t++;
    end
    en_clr = 1'b1;
    @(negedge clk); en_clr = 1'b0;
    chk("R10 en_o cleared", {31'd0, en_o}, 32'd0);
    wait_idle();
    chk("R10 one frame", nfr, 1);
    chk("R10 wb done", mem[32'h100 >> 2], 32'h0000_0000);
    chk("R10 next untouched", mem[32'h110 >> 2], 32'h8000_0000);
    chk("R10 no further fetch", nlog, 5);
    chk("R12 idle at end", {31'd0, idle_o}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; en_set = 1'b0; en_clr = 1'b0; base_addr = '0;
    mem_ack = 1'b0; mem_rdata = '0; xfer_done = 1'b0; xfer_len = '0;
    xfer_err = 1'b0; xfer_last = 1'b0; prev_wait = 1'b0; prev_addr = '0;
    clear_env();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_overflow();
    t_wrap();
    t_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule